// File: doc/BRIEF.md
# Dual-Setting PWM Channel Generator

This block produces one pulse-width-modulated output from a reference clock. A programmable prescaler slows the reference clock down to a tick. The waveform generator counts these ticks through a high phase and then a low phase. Software sets each phase length separately, and each stored count is one less than the number of ticks wanted in that phase. A constant-level override covers 0 % and 100 % duty. A polarity flip inverts the final level, and a tri-state request deasserts the output-enable pin.

In alternating mode the channel runs a primary high/low pair for a programmable number of periods. It then runs a secondary pair for its own number of periods, and the cycle repeats. New counts may be written at any time. The generator copies them into its working set only at the end of a low phase, so it never emits a runt pulse. A reserved modulation-mode bit keeps the output inactive.

Top module: `pwm_dual_gen`

## Requirements
- R1: Reset sets every configuration field to zero. After reset `pwmOut` is 0 and `pwmOe` is 1.
- R2: The primary pair is written at address 1, with the high count in data bits [15:0] and the low count in bits [31:16]. While the run bit (control bit 1) and the tick-enable bit (control bit 0) are set, each period holds the output high for (high+1)·(div+1) reference clocks and low for (low+1)·(div+1).
- R3: When the constant bit (control bit 4) is set, the output holds a steady level while running. The level is 0 when the active high count is 0, and 1 when the active low count is 0 and the high count is not.
- R4: The invert bit (control bit 5) flips the output level while running.
- R5: When the tick-enable bit is cleared while running, the output and the phase counters freeze. Setting the bit again resumes the waveform with full-length phases afterwards.
- R6: Setting the tri-state bit (control bit 6) drives `pwmOe` low within two cycles of the write, and clearing it drives `pwmOe` high. The waveform on `pwmOut` is not affected.
- R7: When the run bit is clear, or the reserved modulation bit (control bit 2) is set, `pwmOut` is 0 whatever the invert bit holds. Clearing the run bit also restarts the generator at the start of a primary high phase.
- R8: The alternate bit (control bit 3) selects alternating mode. The secondary pair is at address 2 with the same layout as the primary pair. The hold counts sit at address 3: primary in bits [7:0], secondary in bits [15:8]. In this mode the primary pair runs for hold1+1 periods, then the secondary pair runs for hold2+1 periods, and the cycle repeats.
- R9: A write to a pair register during a period does not change that period. The new counts apply from the next period.
- R10: The prescaler field is control bits [14:8]. It divides by the field value plus one, from 1 up to 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 primary, 2 secondary, 3 hold |
| wrData | input | 32 | Register write data |
| pwmOut | output | 1 | Registered PWM level |
| pwmOe | output | 1 | Output enable; low requests high impedance |

## Verification
A register write lands on the clock edge after `wrEn` is sampled. `pwmOe` follows one edge after that, so the bench reads it two falling edges after driving the write. The output is registered, so it trails the generator state by one cycle. Because of this delay, every timing check measures run lengths between transitions of `pwmOut`, sampled on falling edges, rather than absolute cycle numbers. After each configuration change the bench waits for a rising transition before it measures, and it checks steady levels only over windows that begin a few cycles after the write.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned DIV_W  = 7;
  localparam int unsigned HOLD_W = 8;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned DATA_W = 2 * CNT_W;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRI  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_SEC  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_HOLD = 2'd3;

  localparam int unsigned BIT_CLKEN  = 0;
  localparam int unsigned BIT_RUN    = 1;
  localparam int unsigned BIT_DS     = 2;
  localparam int unsigned BIT_SECOND = 3;
  localparam int unsigned BIT_CONST  = 4;
  localparam int unsigned BIT_INV    = 5;
  localparam int unsigned BIT_HIZ    = 6;
  localparam int unsigned DIV_LSB    = 8;

  typedef struct packed {
    logic             clkEn;
    logic             runEn;
    logic             dsEn;
    logic             secondEn;
    logic             constEn;
    logic             invert;
    logic             hiZ;
    logic [DIV_W-1:0] div;
  } ctrl_t;

  typedef struct packed {
    logic [CNT_W-1:0] hi;
    logic [CNT_W-1:0] lo;
  } pair_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic tick;
    logic run;
  } strobe_t;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned DIV_W = pwm_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clkEn,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] divCnt;

  assign tick = run && clkEn && (divCnt >= div);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      divCnt <= '0;
    end else if (clkEn) begin
      divCnt <= tick ? '0 : divCnt + 1'b1;
    end
  end

  // R10: with a nonzero divider, ticks are never back to back
  a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0) |=> (!tick || div == '0));
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output ctrl_t             cfg,
  output pair_t             priPair,
  output pair_t             secPair,
  output logic [HOLD_W-1:0] holdA,
  output logic [HOLD_W-1:0] holdB,
  output strobe_t           st,
  output logic              pwmOe
);
  logic tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '0;
      priPair <= '0;
      secPair <= '0;
      holdA   <= '0;
      holdB   <= '0;
    end else if (wrEn) begin
      case (wrAddr)
        ADDR_CTRL: begin
          cfg.clkEn    <= wrData[BIT_CLKEN];
          cfg.runEn    <= wrData[BIT_RUN];
          cfg.dsEn     <= wrData[BIT_DS];
          cfg.secondEn <= wrData[BIT_SECOND];
          cfg.constEn  <= wrData[BIT_CONST];
          cfg.invert   <= wrData[BIT_INV];
          cfg.hiZ      <= wrData[BIT_HIZ];
          cfg.div      <= wrData[DIV_LSB +: DIV_W];
        end
        ADDR_PRI: begin
          priPair.hi <= wrData[CNT_W-1:0];
          priPair.lo <= wrData[DATA_W-1:CNT_W];
        end
        ADDR_SEC: begin
          secPair.hi <= wrData[CNT_W-1:0];
          secPair.lo <= wrData[DATA_W-1:CNT_W];
        end
        default: begin
          holdA <= wrData[HOLD_W-1:0];
          holdB <= wrData[2*HOLD_W-1:HOLD_W];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwmOe <= 1'b1;
    else        pwmOe <= !cfg.hiZ;
  end

  pwm_prescaler #(.DIV_W(DIV_W)) presc_i (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (st.run),
    .clkEn(cfg.clkEn),
    .div  (cfg.div),
    .tick (tick)
  );

  always_comb begin
    st.run  = cfg.runEn && !cfg.dsEn;
    st.tick = tick;
  end

  // R6: a tri-state request drops the enable two edges later
  a_r6_hiz_drops_oe: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrAddr == ADDR_CTRL && wrData[BIT_HIZ])
      |=> ##1 (!pwmOe || $past(wrEn && wrAddr == ADDR_CTRL)));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           st,
  input  pair_t             priPair,
  input  pair_t             secPair,
  input  logic [HOLD_W-1:0] holdA,
  input  logic [HOLD_W-1:0] holdB,
  input  logic              secondEn,
  input  logic              constEn,
  input  logic              invert,
  output logic              pwmOut
);
  logic              phaseHigh;
  logic [CNT_W-1:0]  phaseCnt;
  logic              pairSel;
  logic [HOLD_W-1:0] periodCnt;
  pair_t             act;

  logic              highEnd;
  logic              lowEnd;
  logic [HOLD_W-1:0] curHold;
  logic              nextSel;
  logic [HOLD_W-1:0] nextPeriod;
  logic              level;
  logic              outNext;

  always_comb begin
    highEnd    = phaseHigh && (phaseCnt == act.hi);
    lowEnd     = !phaseHigh && (phaseCnt == act.lo);
    curHold    = pairSel ? holdB : holdA;
    nextSel    = 1'b0;
    nextPeriod = '0;
    if (secondEn) begin
      if (periodCnt == curHold) begin
        nextSel    = !pairSel;
        nextPeriod = '0;
      end else begin
        nextSel    = pairSel;
        nextPeriod = periodCnt + 1'b1;
      end
    end
    level = phaseHigh;
    if (constEn) begin
      if (act.hi == '0)      level = 1'b0;
      else if (act.lo == '0) level = 1'b1;
    end
    outNext = st.run ? (level ^ invert) : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phaseHigh <= 1'b1;
      phaseCnt  <= '0;
      pairSel   <= 1'b0;
      periodCnt <= '0;
      act       <= '0;
    end else if (!st.run) begin
      phaseHigh <= 1'b1;
      phaseCnt  <= '0;
      pairSel   <= 1'b0;
      periodCnt <= '0;
      act       <= priPair;
    end else if (st.tick) begin
      if (highEnd) begin
        phaseHigh <= 1'b0;
        phaseCnt  <= '0;
      end else if (lowEnd) begin
        phaseHigh <= 1'b1;
        phaseCnt  <= '0;
        pairSel   <= nextSel;
        periodCnt <= nextPeriod;
        act       <= nextSel ? secPair : priPair;
      end else begin
        phaseCnt <= phaseCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pwmOut <= 1'b0;
    else        pwmOut <= outNext;
  end

  // R7: an idle or reserved-mode channel drives a low level
  a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !st.run |=> !pwmOut);
  // R2: the high-phase counter never passes the working high count
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    phaseHigh |-> phaseCnt <= act.hi);
  // R5: without a tick the phase state does not move
  a_r5_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (st.run && !st.tick) |=> ($stable(phaseCnt) && $stable(phaseHigh)));
  // R9: working counts change only at a period end or on restart
  a_r9_act_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (st.run && !(st.tick && lowEnd)) |=> ($stable(act) || !st.run));
  // R8: alternation off returns to the primary pair at a period end
  a_r8_primary_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st.run && st.tick && lowEnd && !secondEn) |=> !pairSel);
endmodule

// File: rtl/pwm_dual_gen.sv
module pwm_dual_gen
  import pwm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              pwmOut,
  output logic              pwmOe
);
  ctrl_t             cfg;
  pair_t             priPair;
  pair_t             secPair;
  logic [HOLD_W-1:0] holdA;
  logic [HOLD_W-1:0] holdB;
  strobe_t           st;

  pwm_ctrl ctrl_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .cfg    (cfg),
    .priPair(priPair),
    .secPair(secPair),
    .holdA  (holdA),
    .holdB  (holdB),
    .st     (st),
    .pwmOe  (pwmOe)
  );

  pwm_wave wave_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .st      (st),
    .priPair (priPair),
    .secPair (secPair),
    .holdA   (holdA),
    .holdB   (holdB),
    .secondEn(cfg.secondEn),
    .constEn (cfg.constEn),
    .invert  (cfg.invert),
    .pwmOut  (pwmOut)
  );
endmodule

// File: tb/pwm_dual_gen_tb_top.sv
module pwm_dual_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        pwmOut;
  logic        pwmOe;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_dual_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  typedef struct packed {
    logic [6:0]  d;
    logic [15:0] h;
    logic [15:0] l;
  } vec_t;
  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{d: 7'd0, h: 16'd3, l: 16'd5},
    '{d: 7'd1, h: 16'd2, l: 16'd2},
    '{d: 7'd3, h: 16'd0, l: 16'd4},
    '{d: 7'd2, h: 16'd7, l: 16'd1},
    '{d: 7'd4, h: 16'd1, l: 16'd0}
  };

  function automatic logic [31:0] ctl(bit ce, bit run, bit ds, bit sec,
                                      bit cnst, bit inv, bit hiz, int div);
    logic [31:0] w;
    w = '0;
    w[0] = ce; w[1] = run; w[2] = ds; w[3] = sec;
    w[4] = cnst; w[5] = inv; w[6] = hiz;
    w[14:8] = div[6:0];
    return w;
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called on a falling edge; ends on the next falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic runLen(input logic v, output int n);
    n = 0;
    while (pwmOut === v && n < 4000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic waitRise();
    int k;
    k = 0;
    while (pwmOut !== 1'b0 && k < 4000) begin k++; @(negedge clk); end
    while (pwmOut !== 1'b1 && k < 8000) begin k++; @(negedge clk); end
  endtask

  task automatic steady(input string tag, input logic v, input int cycles);
    int bad;
    bad = 0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < cycles; i++) begin
      if (pwmOut !== v) bad++;
      @(negedge clk);
    end
    check(tag, bad, 0);
  endtask

  task automatic printSummary();
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      printSummary();
      $finish;
    end
  end

  initial begin
    int hi, lo;
    logic frozen;
    int moved;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset pwmOut", int'(pwmOut), 0);
    check("R1 reset pwmOe", int'(pwmOe), 1);
    steady("R1 idle after reset", 1'b0, 10);

    // Table walk: R2 high/low durations over several dividers
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, 32'd0);
      wr(2'd1, {VECS[i].l, VECS[i].h});
      wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 0, int'(VECS[i].d)));
      waitRise();
      runLen(1'b1, hi);
      runLen(1'b0, lo);
      check($sformatf("R2 vec%0d high", i), hi,
            (int'(VECS[i].h) + 1) * (int'(VECS[i].d) + 1));
      check($sformatf("R2 vec%0d low", i), lo,
            (int'(VECS[i].l) + 1) * (int'(VECS[i].d) + 1));
    end

    // R10: largest divider field
    wr(2'd0, 32'd0);
    wr(2'd1, {16'd0, 16'd0});
    wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 0, 127));
    waitRise();
    runLen(1'b1, hi);
    runLen(1'b0, lo);
    check("R10 div128 high", hi, 128);
    check("R10 div128 low", lo, 128);

    // R4: inverted waveform
    wr(2'd0, 32'd0);
    wr(2'd1, {16'd4, 16'd2});
    wr(2'd0, ctl(1, 1, 0, 0, 0, 1, 0, 1));
    waitRise();
    runLen(1'b1, hi);
    runLen(1'b0, lo);
    check("R4 inverted high run", hi, 10);
    check("R4 inverted low run", lo, 6);

    // R3: constant levels
    wr(2'd0, 32'd0);
    wr(2'd1, {16'd5, 16'd0});
    wr(2'd0, ctl(1, 1, 0, 0, 1, 0, 0, 0));
    steady("R3 const low", 1'b0, 100);
    wr(2'd0, 32'd0);
    wr(2'd1, {16'd0, 16'd5});
    wr(2'd0, ctl(1, 1, 0, 0, 1, 0, 0, 0));
    steady("R3 const high", 1'b1, 100);

    // R7: idle and reserved mode force low even when inverted
    wr(2'd0, ctl(1, 0, 0, 0, 0, 1, 0, 0));
    steady("R7 idle inverted", 1'b0, 30);
    wr(2'd1, {16'd3, 16'd3});
    wr(2'd0, ctl(1, 1, 1, 0, 0, 1, 0, 0));
    steady("R7 reserved mode", 1'b0, 30);

    // R5: tick enable freezes the waveform
    wr(2'd0, 32'd0);
    wr(2'd1, {16'd9, 16'd9});
    wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    waitRise();
    wr(2'd0, ctl(0, 1, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    frozen = pwmOut;
    moved = 0;
    for (int i = 0; i < 100; i++) begin
      if (pwmOut !== frozen) moved++;
      @(negedge clk);
    end
    check("R5 frozen level is high", int'(frozen), 1);
    check("R5 no movement while gated", moved, 0);
    wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    waitRise();
    runLen(1'b1, hi);
    runLen(1'b0, lo);
    check("R5 high after resume", hi, 10);
    check("R5 low after resume", lo, 10);

    // R6: tri-state request
    wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 1, 0));
    @(negedge clk);
    check("R6 oe low", int'(pwmOe), 0);
    waitRise();
    runLen(1'b1, hi);
    check("R6 waveform unaffected", hi, 10);
    wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 0, 0));
    @(negedge clk);
    check("R6 oe restored", int'(pwmOe), 1);

    // R9: write mid-period applies at next period
    waitRise();
    wr(2'd1, {16'd5, 16'd3});
    runLen(1'b1, hi);
    runLen(1'b0, lo);
    check("R9 current high keeps old count", hi, 9);
    check("R9 current low keeps old count", lo, 10);
    runLen(1'b1, hi);
    runLen(1'b0, lo);
    check("R9 next high uses new count", hi, 4);
    check("R9 next low uses new count", lo, 6);

    // R8: alternating pairs
    wr(2'd0, 32'd0);
    wr(2'd1, {16'd1, 16'd1});
    wr(2'd2, {16'd2, 16'd4});
    wr(2'd3, {16'd2, 8'd2, 8'd1});
    wr(2'd0, ctl(1, 1, 0, 1, 0, 0, 0, 0));
    waitRise();
    for (int p = 0; p < 10; p++) begin
      runLen(1'b1, hi);
      runLen(1'b0, lo);
      check($sformatf("R8 period%0d high", p), hi, (p % 5 < 2) ? 2 : 5);
      check($sformatf("R8 period%0d low", p), lo, (p % 5 < 2) ? 2 : 3);
    end

    done = 1'b1;
    printSummary();
    $finish;
  end
endmodule